// File: doc/BRIEF.md
# Streaming SPD CRC Checker

This block watches a byte stream that carries a serial presence-detect image, one byte per valid cycle. It folds the leading 510 bytes into a 16-bit CRC and captures the two bytes after them, which hold the checksum written into the image. When the last of those two bytes arrives, it reports whether the running CRC equals the stored checksum.

The CRC it computed is always available as two bytes. A tool that edits the image can write those bytes back at offsets 510 and 511 to re-sign it. A start-of-image strobe restarts the count and the CRC at any time, so an image may be aborted and resent. Bytes that arrive after offset 511 (the rest of a 1024-byte image) pass through without effect.

Top module: `spd_crc_check`

## Requirements
- R1: `calc_crc_o` is the CRC-16 of the image bytes at offsets 0 to 509. The CRC uses polynomial 0x1021 and initial value 0x0000, shifts MSB first, and applies no reflection and no final XOR. For example, the ASCII string "123456789" gives 0x31C3. The register updates one edge after each accepted byte.
- R2: Bytes at offsets 510 and 511 do not enter the CRC. They are captured into `stored_crc_o`, with offset 510 as bits 7:0 and offset 511 as bits 15:8. For example, 0x37 followed by 0x3E reads as 0x3E37.
- R3: `done_o` is high for exactly one cycle, the cycle after the byte at offset 511 is accepted.
- R4: In the `done_o` cycle, `match_o` is 1 when the calculated and stored values are equal, and 0 otherwise. It keeps that value until the next start strobe or reset.
- R5: `fix_lo_o` and `fix_hi_o` give the low and high byte of the calculated CRC. These are the values to write at offsets 510 and 511 to re-sign an edited image.
- R6: A start strobe `sof_i` clears the CRC, the stored value, the match flag and the byte counter. If `in_valid_i` is high in the same cycle, that byte is taken as offset 0. A start strobe in the middle of an image abandons the old image.
- R7: Cycles with `in_valid_i` low change nothing and do not advance the offset.
- R8: Bytes after offset 511 are ignored. The CRC and stored value stay unchanged, and no further `done_o` is produced until the next start strobe.
- R9: After reset, the CRC, the stored value, `done_o` and `match_o` are all zero, and the next valid byte is offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start-of-image strobe |
| in_valid_i | input | 1 | Byte on `in_data_i` is valid this cycle |
| in_data_i | input | 8 | Image byte |
| calc_crc_o | output | 16 | Running CRC over offsets 0 to 509 |
| stored_crc_o | output | 16 | Checksum captured from offsets 510 and 511 |
| fix_lo_o | output | 8 | Byte to write at offset 510 |
| fix_hi_o | output | 8 | Byte to write at offset 511 |
| done_o | output | 1 | One-cycle pulse after offset 511 is accepted |
| match_o | output | 1 | Calculated CRC equals stored checksum |

## Verification
The bench feeds the standard "123456789" string into the CRC. A wrong polynomial, a wrong initial value or reflected bit order shows up there at once. It sends a 0x37, 0x3E pair to catch a design that swaps the stored bytes, and sends a correctly signed image so that a design which folds offsets 510 and 511 into the CRC reports a false mismatch. Idle gaps within the image, extra bytes after offset 511 and a restart in the middle of an image target three faults: counters that advance without a valid byte, a second `done_o` from a counter that wraps, and stale CRC state that survives a start strobe.

// File: rtl/spd_crc_pkg.sv
package spd_crc_pkg;
  localparam int unsigned CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'h0000;

  // One byte through the CRC, most significant bit first.
  function automatic logic [CRC_W-1:0] crc16_step(input logic [CRC_W-1:0] cur,
                                                  input logic [7:0] din);
    logic [CRC_W-1:0] c;
    logic fb;
    c = cur;
    for (int b = 7; b >= 0; b--) begin
      fb = c[CRC_W-1] ^ din[b];
      c = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/spd_byte_tracker.sv
module spd_byte_tracker #(
  parameter int unsigned CHECK_BYTES = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sof_i,
  input  logic valid_i,
  output logic crc_step_o,
  output logic cap_lo_o,
  output logic cap_hi_o
);
  localparam int unsigned CW        = $clog2(CHECK_BYTES + 1);
  localparam int unsigned CRC_BYTES = CHECK_BYTES - 2;

  logic [CW-1:0] count_q;
  logic [CW-1:0] idx;
  logic          accept;

  // A start strobe makes the current byte offset zero.
  assign idx        = sof_i ? '0 : count_q;
  assign accept     = valid_i && (idx < CW'(CHECK_BYTES));
  assign crc_step_o = accept && (idx < CW'(CRC_BYTES));
  assign cap_lo_o   = accept && (idx == CW'(CRC_BYTES));
  assign cap_hi_o   = accept && (idx == CW'(CHECK_BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (accept) count_q <= idx + CW'(1);
    else if (sof_i)  count_q <= '0;
  end
endmodule

// File: rtl/spd_crc_engine.sv
module spd_crc_engine
  import spd_crc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [7:0]       data_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] base;

  assign base = clear_i ? CRC_SEED : crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= CRC_SEED;
    else if (step_i)  crc_q <= crc16_step(base, data_i);
    else if (clear_i) crc_q <= CRC_SEED;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/spd_crc_capture.sv
module spd_crc_capture
  import spd_crc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             cap_lo_i,
  input  logic             cap_hi_i,
  input  logic [7:0]       data_i,
  input  logic [CRC_W-1:0] crc_i,
  output logic [CRC_W-1:0] stored_o,
  output logic             done_o,
  output logic             match_o
);
  logic [CRC_W-1:0] stored_q;
  logic             done_q;
  logic             match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stored_q <= '0;
      done_q   <= 1'b0;
      match_q  <= 1'b0;
    end else begin
      done_q <= cap_hi_i;
      if (clear_i) begin
        stored_q <= '0;
        match_q  <= 1'b0;
      end else begin
        if (cap_lo_i) stored_q[7:0] <= data_i;
        if (cap_hi_i) begin
          stored_q[15:8] <= data_i;
          match_q        <= (crc_i == {data_i, stored_q[7:0]});
        end
      end
    end
  end

  assign stored_o = stored_q;
  assign done_o   = done_q;
  assign match_o  = match_q;
endmodule

// File: rtl/spd_crc_check.sv
module spd_crc_check
  import spd_crc_pkg::*;
#(
  parameter int unsigned CHECK_BYTES = 512
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sof_i,
  input  logic        in_valid_i,
  input  logic [7:0]  in_data_i,
  output logic [15:0] calc_crc_o,
  output logic [15:0] stored_crc_o,
  output logic [7:0]  fix_lo_o,
  output logic [7:0]  fix_hi_o,
  output logic        done_o,
  output logic        match_o
);
  // Named internal events, visible to the bound checker.
  logic w_crc_step;
  logic w_cap_lo;
  logic w_cap_hi;
  logic [CRC_W-1:0] w_crc;

  spd_byte_tracker #(.CHECK_BYTES(CHECK_BYTES)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sof_i      (sof_i),
    .valid_i    (in_valid_i),
    .crc_step_o (w_crc_step),
    .cap_lo_o   (w_cap_lo),
    .cap_hi_o   (w_cap_hi)
  );

  spd_crc_engine u_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (sof_i),
    .step_i  (w_crc_step),
    .data_i  (in_data_i),
    .crc_o   (w_crc)
  );

  spd_crc_capture u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (sof_i),
    .cap_lo_i (w_cap_lo),
    .cap_hi_i (w_cap_hi),
    .data_i   (in_data_i),
    .crc_i    (w_crc),
    .stored_o (stored_crc_o),
    .done_o   (done_o),
    .match_o  (match_o)
  );

  assign calc_crc_o = w_crc;
  assign fix_lo_o   = w_crc[7:0];
  assign fix_hi_o   = w_crc[15:8];
endmodule

// File: rtl/spd_crc_check_sva.sv
module spd_crc_check_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sof_i,
  input logic        in_valid_i,
  input logic        crc_step,
  input logic        cap_lo,
  input logic        cap_hi,
  input logic [15:0] calc,
  input logic [15:0] stored,
  input logic        done_o,
  input logic        match_o
);
  logic seen_hi;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seen_hi <= 1'b0;
    else if (sof_i)  seen_hi <= 1'b0;
    else if (cap_hi) seen_hi <= 1'b1;
  end

  p_done_follows_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_hi |=> done_o);
  p_done_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(cap_hi));
  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_match_agrees_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (match_o == (calc == stored)));
  p_match_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_hi && !sof_i) |=> $stable(match_o));
  p_stored_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_lo && !cap_hi && !sof_i) |=> $stable(stored));
  p_crc_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!crc_step && !sof_i) |=> $stable(calc));
  p_sof_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i && !in_valid_i) |=> (calc == 16'h0000 && stored == 16'h0000));
  p_single_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_hi && !sof_i) |-> !cap_hi);
  p_step_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({crc_step, cap_lo, cap_hi}) <= 1);
endmodule

bind spd_crc_check spd_crc_check_sva u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sof_i      (sof_i),
  .in_valid_i (in_valid_i),
  .crc_step   (w_crc_step),
  .cap_lo     (w_cap_lo),
  .cap_hi     (w_cap_hi),
  .calc       (calc_crc_o),
  .stored     (stored_crc_o),
  .done_o     (done_o),
  .match_o    (match_o)
);

// File: tb/spd_crc_check_test.sv
`timescale 1ns/1ps
module spd_crc_check_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sof_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [7:0]  in_data_i = 8'h00;
  logic [15:0] calc_crc_o, stored_crc_o;
  logic [7:0]  fix_lo_o, fix_hi_o;
  logic        done_o, match_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  spd_crc_check uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sof_i(sof_i), .in_valid_i(in_valid_i),
    .in_data_i(in_data_i), .calc_crc_o(calc_crc_o), .stored_crc_o(stored_crc_o),
    .fix_lo_o(fix_lo_o), .fix_hi_o(fix_hi_o), .done_o(done_o), .match_o(match_o)
  );

  // Reference model state
  int          m_off;
  logic [15:0] m_crc, m_st;
  logic        m_done, m_match;

  // Table-free CRC, byte xored into the top then eight shifts.
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_apply(input logic s, input logic v, input logic [7:0] d);
    if (s) begin m_off = 0; m_crc = 0; m_st = 0; m_match = 0; end
    m_done = 0;
    if (v && m_off < 512) begin
      if (m_off < 510) m_crc = ref_crc(m_crc, d);
      else if (m_off == 510) m_st[7:0] = d;
      else begin
        m_st[15:8] = d; m_done = 1; m_match = (m_crc == m_st);
      end
      m_off++;
    end
  endtask

  task automatic compare_all();
    check("R1 calc_crc", calc_crc_o, m_crc);
    check("R2 stored_crc", stored_crc_o, m_st);
    check("R3 done", {15'd0, done_o}, {15'd0, m_done});
    check("R4 match", {15'd0, match_o}, {15'd0, m_match});
    check("R5 fix bytes", {fix_hi_o, fix_lo_o}, m_crc);
  endtask

  task automatic tick(input logic s, input logic v, input logic [7:0] d);
    sof_i = s; in_valid_i = v; in_data_i = d;
    @(posedge clk_i);
    model_apply(s, v, d);
    @(negedge clk_i);
    compare_all();
    sof_i = 0; in_valid_i = 0;
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((i * seed) + (i >> 3) + seed);
  endfunction

  localparam string KAT = "123456789";

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] sig;
    logic [15:0] hold_c, hold_s;
    m_off = 0; m_crc = 0; m_st = 0; m_done = 0; m_match = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R9 reset state
    check("R9 reset calc", calc_crc_o, 16'h0000);
    check("R9 reset stored", stored_crc_o, 16'h0000);
    check("R9 reset done/match", {14'd0, done_o, match_o}, 16'h0000);

    // Image 1: known-answer head, correct signature
    for (int i = 0; i < 9; i++) tick(i == 0, 1'b1, KAT[i]);
    check("R1 known answer 123456789", calc_crc_o, 16'h31C3);
    for (int i = 9; i < 510; i++) tick(1'b0, 1'b1, pat(7, i));
    sig = m_crc;
    tick(1'b0, 1'b1, sig[7:0]);
    check("R3 no done after offset 510", {15'd0, done_o}, 16'd0);
    tick(1'b0, 1'b1, sig[15:8]);
    check("R3 done after offset 511", {15'd0, done_o}, 16'd1);
    check("R4 signed image matches", {15'd0, match_o}, 16'd1);
    check("R2 signature not folded into crc", calc_crc_o, sig);
    tick(1'b0, 1'b0, 8'h00);
    check("R3 done is one cycle", {15'd0, done_o}, 16'd0);
    check("R4 match held", {15'd0, match_o}, 16'd1);

    // Image 2: gaps, bad signature 0x37 0x3E, trailing bytes
    tick(1'b1, 1'b1, pat(13, 0));
    for (int i = 1; i < 510; i++) begin
      if (i % 3 == 0) tick(1'b0, 1'b0, 8'hA5);
      tick(1'b0, 1'b1, pat(13, i));
    end
    hold_c = m_crc;
    tick(1'b0, 1'b0, 8'h55);
    check("R7 idle byte ignored", calc_crc_o, hold_c);
    tick(1'b0, 1'b1, 8'h37);
    tick(1'b0, 1'b1, 8'h3E);
    check("R2 stored little-endian", stored_crc_o, 16'h3E37);
    check("R4 mismatch flag", {15'd0, match_o}, {15'd0, hold_c == 16'h3E37});
    check("R5 re-sign low byte", {8'd0, fix_lo_o}, {8'd0, hold_c[7:0]});
    check("R5 re-sign high byte", {8'd0, fix_hi_o}, {8'd0, hold_c[15:8]});
    hold_s = stored_crc_o;
    for (int i = 512; i < 540; i++) begin
      tick(1'b0, 1'b1, pat(5, i));
      check("R8 no second done", {15'd0, done_o}, 16'd0);
    end
    check("R8 crc unchanged past end", calc_crc_o, hold_c);
    check("R8 stored unchanged past end", stored_crc_o, hold_s);

    // Image 3: abandoned mid-way, restarted with a byte on the strobe
    tick(1'b1, 1'b1, 8'hFF);
    for (int i = 1; i < 200; i++) tick(1'b0, 1'b1, pat(3, i));
    tick(1'b1, 1'b1, pat(11, 0));
    check("R6 restart takes byte as offset 0", calc_crc_o, ref_crc(16'h0000, pat(11, 0)));
    for (int i = 1; i < 510; i++) tick(1'b0, 1'b1, pat(11, i));
    sig = m_crc;
    tick(1'b0, 1'b1, sig[7:0]);
    tick(1'b0, 1'b1, sig[15:8]);
    check("R6 restarted image matches", {15'd0, match_o}, 16'd1);

    // Strobe without data clears everything
    tick(1'b1, 1'b0, 8'h00);
    check("R6 strobe clears crc", calc_crc_o, 16'h0000);
    check("R6 strobe clears stored", stored_crc_o, 16'h0000);
    check("R6 strobe clears match", {15'd0, match_o}, 16'd0);
    tick(1'b0, 1'b1, 8'h31);
    check("R6 next byte is offset 0", calc_crc_o, ref_crc(16'h0000, 8'h31));

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule